// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for one display pipe. Six packed 32-bit timing words set the horizontal and vertical totals, blanking windows and sync windows. A source-size word limits the visible picture. From these the block runs a pixel counter and a line counter and drives horizontal sync, vertical sync, blank and data-enable. It also gives the byte address of the current line in a linear frame buffer, and a flag that says whether the plane settings are legal.

Every timing word keeps `(first - 1)` in bits 15:0 and `(last-plus-one - 1)` in bits 31:16. For a total word the pair is `(active - 1, total - 1)`. Bit 31 of the pipe control word asks the pipe to run. Bit 30 of the pipe state word reports that it is running. A start waits for the frame origin, and a stop waits until the frame in flight has ended.

The timing words are copied into a shadow set only while the pipe is idle, which means bit 31 is clear and bit 30 is clear. Changes made to the inputs at any other time have no effect until the pipe is idle again.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, pipe state bit 30 is 0, blank is 1, both syncs and data-enable are 0, and both counters are 0.
- R2: At the first clock edge that samples pipe control bit 31 high while the pipe is stopped, bit 30 becomes 1. The pixel counter and line counter then start from (0,0), and the pixel counter advances once per clock after that.
- R3: The pixel counter runs from 0 to htotal_hi and then wraps to 0. The line counter advances only on that wrap and itself wraps after vtotal_hi.
- R4: hsync is 1 exactly when the pipe runs and hsync_lo < x <= hsync_hi.
- R5: vsync is 1 exactly when the pipe runs and vsync_lo < y <= vsync_hi.
- R6: blank is 1 when x lies in (hblank_lo, hblank_hi] or y lies in (vblank_lo, vblank_hi]. Data-enable is 1 only when the pipe runs, the pixel is not blanked, x <= htotal_lo, y <= vtotal_lo, x <= source bits 31:16, and y <= source bits 15:0.
- R7: After bit 31 is cleared, bit 30 stays 1 through the last pixel of the current frame (x = htotal_hi, y = vtotal_hi). It then clears at the same edge that wraps both counters to 0.
- R8: If bit 31 is set again before that last pixel, the pipe keeps running without a break.
- R9: Timing and source words are taken only while bit 31 and bit 30 are both 0. Changes made while the pipe runs or drains have no effect.
- R10: line_addr equals surface base plus linear offset plus y times stride.
- R11: plane_on is 1 only when plane control bit 31 is 1, plane control bits 29:26 equal 0110 (32-bit BGRX), and the stride is a multiple of 64.
- R12: While the pipe is stopped, blank is 1 and hsync, vsync and data-enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_ctl | input | 32 | Pipe control; bit 31 requests running |
| pipe_state | output | 32 | Control word with bit 30 replaced by the running status |
| htot_w | input | 32 | Horizontal active-1 / total-1 |
| hblk_w | input | 32 | Horizontal blank window |
| hsyn_w | input | 32 | Horizontal sync window |
| vtot_w | input | 32 | Vertical active-1 / total-1 |
| vblk_w | input | 32 | Vertical blank window |
| vsyn_w | input | 32 | Vertical sync window |
| src_w | input | 32 | Source size: v-1 in 15:0, h-1 in 31:16 |
| surf_base | input | AW | Frame buffer base address |
| lin_off | input | AW | Linear offset added to the base |
| stride | input | SW | Bytes per line |
| plane_ctl | input | 32 | Plane enable (31) and pixel format (29:26) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Blanking indicator |
| de | output | 1 | Active-video data enable |
| x_pos | output | CW | Pixel counter |
| y_pos | output | CW | Line counter |
| line_addr | output | AW | Byte address of the current line |
| plane_on | output | 1 | Plane enabled with a legal format and stride |

## Verification
The hardest case to reach is a change to the timing inputs while a frame is running. Checking it means holding the pipe busy across the change, then watching the old raster continue, then dropping the request and waiting through the drain. Only after that can the new geometry be shown to take effect. The bench does this in one scenario against a cycle model that copies the shadow only when idle. A second case is a request re-raised partway through a drain, which must not cause even one idle cycle at the frame boundary.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int HALF      = 16;
    localparam int RUN_REQ   = 31;
    localparam int RUN_STAT  = 30;
    localparam logic [3:0] FMT_BGRX = 4'b0110;

    typedef struct packed {
        logic [31:0] tot;
        logic [31:0] blk;
        logic [31:0] syn;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t   h;
        axis_cfg_t   v;
        logic [31:0] src;
    } pipe_cfg_t;
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
    import dtg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  axis_cfg_t     cfg,
    input  logic [CW-1:0] src_last,
    output logic [CW-1:0] cnt,
    output logic          last,
    output logic          in_act,
    output logic          in_blk,
    output logic          in_syn
);
    logic [CW-1:0] tot_lo, tot_hi, blk_lo, blk_hi, syn_lo, syn_hi;
    logic [CW-1:0] cnt_d, cnt_q;

    assign tot_lo = cfg.tot[CW-1:0];
    assign tot_hi = cfg.tot[HALF+CW-1:HALF];
    assign blk_lo = cfg.blk[CW-1:0];
    assign blk_hi = cfg.blk[HALF+CW-1:HALF];
    assign syn_lo = cfg.syn[CW-1:0];
    assign syn_hi = cfg.syn[HALF+CW-1:HALF];

    assign last   = (cnt_q >= tot_hi);
    assign in_act = (cnt_q <= tot_lo) && (cnt_q <= src_last);
    assign in_blk = (cnt_q > blk_lo) && (cnt_q <= blk_hi);
    assign in_syn = (cnt_q > syn_lo) && (cnt_q <= syn_hi);
    assign cnt    = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step) cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= tot_hi);
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));
endmodule

// File: rtl/dtg_plane.sv
module dtg_plane
    import dtg_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 16,
    parameter int CW = 16
) (
    input  logic [CW-1:0] y,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  logic [SW-1:0] stride,
    input  logic [31:0]   ctl,
    output logic [AW-1:0] addr,
    output logic          on
);
    localparam int ALIGN = 6;
    logic unused_ctl_bits;

    assign unused_ctl_bits = ^{ctl[30], ctl[25:0]};

    always_comb begin
        addr = base + offset + AW'(y) * AW'(stride);
        on   = ctl[31] && (ctl[29:26] == FMT_BGRX) && (stride[ALIGN-1:0] == '0);
    end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int CW = 16,
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   pipe_ctl,
    output logic [31:0]   pipe_state,
    input  logic [31:0]   htot_w,
    input  logic [31:0]   hblk_w,
    input  logic [31:0]   hsyn_w,
    input  logic [31:0]   vtot_w,
    input  logic [31:0]   vblk_w,
    input  logic [31:0]   vsyn_w,
    input  logic [31:0]   src_w,
    input  logic [AW-1:0] surf_base,
    input  logic [AW-1:0] lin_off,
    input  logic [SW-1:0] stride,
    input  logic [31:0]   plane_ctl,
    output logic          hsync,
    output logic          vsync,
    output logic          blank,
    output logic          de,
    output logic [CW-1:0] x_pos,
    output logic [CW-1:0] y_pos,
    output logic [AW-1:0] line_addr,
    output logic          plane_on
);
    typedef struct packed {
        logic      run;
        pipe_cfg_t cfg;
    } state_t;

    state_t st_d, st_q;
    logic   req;
    logic   h_last, h_act, h_blk, h_syn;
    logic   v_last, v_act, v_blk, v_syn;

    assign req = pipe_ctl[RUN_REQ];

    dtg_axis #(.CW(CW)) u_h (
        .clk(clk), .rst_n(rst_n), .step(st_q.run), .cfg(st_q.cfg.h),
        .src_last(st_q.cfg.src[HALF+CW-1:HALF]), .cnt(x_pos),
        .last(h_last), .in_act(h_act), .in_blk(h_blk), .in_syn(h_syn)
    );

    dtg_axis #(.CW(CW)) u_v (
        .clk(clk), .rst_n(rst_n), .step(st_q.run && h_last), .cfg(st_q.cfg.v),
        .src_last(st_q.cfg.src[CW-1:0]), .cnt(y_pos),
        .last(v_last), .in_act(v_act), .in_blk(v_blk), .in_syn(v_syn)
    );

    dtg_plane #(.AW(AW), .SW(SW), .CW(CW)) u_plane (
        .y(y_pos), .base(surf_base), .offset(lin_off), .stride(stride),
        .ctl(plane_ctl), .addr(line_addr), .on(plane_on)
    );

    always_comb begin
        st_d = st_q;
        if (!req && !st_q.run) begin
            st_d.cfg.h   = '{tot: htot_w, blk: hblk_w, syn: hsyn_w};
            st_d.cfg.v   = '{tot: vtot_w, blk: vblk_w, syn: vsyn_w};
            st_d.cfg.src = src_w;
        end
        if (!st_q.run && req)
            st_d.run = 1'b1;
        else if (st_q.run && !req && h_last && v_last)
            st_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pipe_state           = pipe_ctl;
        pipe_state[RUN_STAT] = st_q.run;
        hsync = st_q.run && h_syn;
        vsync = st_q.run && v_syn;
        blank = !st_q.run || h_blk || v_blk;
        de    = st_q.run && !h_blk && !v_blk && h_act && v_act;
    end

    // R2
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> (x_pos == '0) && (y_pos == '0));
    // R7
    stop_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> (x_pos == '0) && (y_pos == '0) && $past(!req));
    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> $stable(st_q.cfg));
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_state[RUN_STAT] |-> blank && !hsync && !vsync && !de);
endmodule

// File: tb/disp_timing_gen_test.sv
module disp_timing_gen_test;
    localparam int CW = 16;
    localparam int AW = 32;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   pipe_ctl = '0;
    logic [31:0]   pipe_state;
    logic [31:0]   htot_w, hblk_w, hsyn_w, vtot_w, vblk_w, vsyn_w, src_w;
    logic [AW-1:0] surf_base, lin_off;
    logic [SW-1:0] stride;
    logic [31:0]   plane_ctl;
    logic          hsync, vsync, blank, de, plane_on;
    logic [CW-1:0] x_pos, y_pos;
    logic [AW-1:0] line_addr;

    int total = 0;
    int bad   = 0;

    // bench model state
    bit          erun = 0;
    int          ex = 0, ey = 0;
    logic [31:0] m_ht = '0, m_hb = '0, m_hs = '0, m_vt = '0, m_vb = '0, m_vs = '0, m_src = '0;

    always #10 clk = ~clk;

    disp_timing_gen #(.CW(CW), .AW(AW), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .pipe_ctl(pipe_ctl), .pipe_state(pipe_state),
        .htot_w(htot_w), .hblk_w(hblk_w), .hsyn_w(hsyn_w),
        .vtot_w(vtot_w), .vblk_w(vblk_w), .vsyn_w(vsyn_w), .src_w(src_w),
        .surf_base(surf_base), .lin_off(lin_off), .stride(stride),
        .plane_ctl(plane_ctl), .hsync(hsync), .vsync(vsync), .blank(blank),
        .de(de), .x_pos(x_pos), .y_pos(y_pos), .line_addr(line_addr),
        .plane_on(plane_on)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit win(input int c, input logic [31:0] w);
        return (c > int'(w[15:0])) && (c <= int'(w[31:16]));
    endfunction

    // compare outputs with the model, then move one clock forward
    task automatic tick(input string sc);
        bit  hb, vb, e_de, nrun, req;
        int  nx, ny;
        string q;
        q  = erun ? sc : "R12";
        hb = win(ex, m_hb);
        vb = win(ey, m_vb);
        e_de = erun && !hb && !vb && ex <= int'(m_ht[15:0]) && ey <= int'(m_vt[15:0])
               && ex <= int'(m_src[31:16]) && ey <= int'(m_src[15:0]);
        chk({sc, " run R2"}, pipe_state[30], erun);
        chk({q, " x R3"}, x_pos, ex);
        chk({q, " y R3"}, y_pos, ey);
        chk({q, " hsync R4"}, hsync, erun && win(ex, m_hs));
        chk({q, " vsync R5"}, vsync, erun && win(ey, m_vs));
        chk({q, " blank R6"}, blank, !erun || hb || vb);
        chk({q, " de R6"}, de, e_de);
        chk({q, " addr R10"}, line_addr, surf_base + lin_off + AW'(ey) * AW'(stride));
        req  = pipe_ctl[31];
        nrun = erun; nx = ex; ny = ey;
        if (erun) begin
            if (ex == int'(m_ht[31:16])) begin
                nx = 0;
                ny = (ey == int'(m_vt[31:16])) ? 0 : ey + 1;
                if (!req && ey == int'(m_vt[31:16])) nrun = 0;
            end else nx = ex + 1;
        end else if (req) nrun = 1;
        if (!req && !erun) begin
            m_ht = htot_w; m_hb = hblk_w; m_hs = hsyn_w;
            m_vt = vtot_w; m_vb = vblk_w; m_vs = vsyn_w; m_src = src_w;
        end
        erun = nrun; ex = nx; ey = ny;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        htot_w = {16'd11, 16'd7};  hblk_w = {16'd11, 16'd7};  hsyn_w = {16'd10, 16'd8};
        vtot_w = {16'd5, 16'd3};   vblk_w = {16'd5, 16'd3};   vsyn_w = {16'd4, 16'd3};
        src_w  = {16'd7, 16'd3};
        surf_base = 32'h1000; lin_off = 32'h40; stride = 16'd64; plane_ctl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 run", pipe_state[30], 1'b0);
        chk("R1 blank", blank, 1'b1);
        chk("R1 syncs", {hsync, vsync, de}, 3'b000);
        chk("R1 counters", {x_pos, y_pos}, '0);
    endtask

    task automatic t_plane;
        plane_ctl = 32'h9800_0000; stride = 16'd128; #1;
        chk("R11 legal", plane_on, 1'b1);
        plane_ctl = 32'h9C00_0000; #1;
        chk("R11 bad format", plane_on, 1'b0);
        plane_ctl = 32'h1800_0000; #1;
        chk("R11 disabled", plane_on, 1'b0);
        plane_ctl = 32'h9800_0000; stride = 16'd96; #1;
        chk("R11 stride", plane_on, 1'b0);
        stride = 16'd64;
        @(negedge clk);
    endtask

    task automatic t_frames;
        tick("R1");
        pipe_ctl[31] = 1'b1;
        for (int i = 0; i < 1 + 72 * 2; i++) tick("R2");
    endtask

    task automatic t_freeze;
        htot_w = {16'd7, 16'd5}; hblk_w = {16'd7, 16'd5}; hsyn_w = {16'd6, 16'd5};
        for (int i = 0; i < 40; i++) tick("R9");
        pipe_ctl[31] = 1'b0;
        for (int i = 0; i < 200 && erun; i++) tick("R7");
        chk("R7 stopped", pipe_state[30], 1'b0);
        for (int i = 0; i < 8; i++) tick("R12");
        pipe_ctl[31] = 1'b1;
        for (int i = 0; i < 60; i++) tick("R9");
    endtask

    task automatic t_drain_cancel;
        pipe_ctl[31] = 1'b0;
        for (int i = 0; i < 5; i++) tick("R8");
        pipe_ctl[31] = 1'b1;
        for (int i = 0; i < 100; i++) tick("R8");
        chk("R8 still running", pipe_state[30], 1'b1);
    endtask

    task automatic t_source;
        pipe_ctl[31] = 1'b0;
        for (int i = 0; i < 200 && erun; i++) tick("R7");
        src_w = {16'd4, 16'd2};
        tick("R12");
        pipe_ctl[31] = 1'b1;
        for (int i = 0; i < 60; i++) tick("R6");
    endtask

    initial begin
        t_reset();
        t_plane();
        t_frames();
        t_freeze();
        t_drain_cancel();
        t_source();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule